// File: doc/BRIEF.md
# LED Fade Ramp Generator

This block turns the on/off gate that a blink sequencer produces for each LED channel into a stepped 5-bit drive code. When a gate rises, the channel climbs from fully off to its programmed brightness. When it falls, the channel descends back to off. How long a ramp lasts is not fixed. Each group of channels selects it as a fraction of the running blink period, and the rising and falling directions take separate selections. The channels of a group share the slope selection and the period, and each channel has its own gate, level and enable.

A drive code of 0 still means the lowest non-zero current. Each channel therefore walks an internal position from 0 (dark) to level+1. The output-enable is high whenever the position is non-zero, and the code presented is position minus one. Pacing is computed again from the live inputs on every cycle. A gate that reverses partway through a ramp turns the ramp around from wherever it stands.

Top module: `fade_slope_gen`

## Requirements
- R1: After synchronous reset every channel presents code 0 with its output-enable low.
- R2: The 6-bit slope configuration carries the rising slope code in bits 2:0 and the falling slope code in bits 5:3. The rising code applies while a channel's position is below its target, and the falling code applies while it is above.
- R3: With H = period_ticks/2 (floor), a slope code sets the ramp span as follows: 1 gives H/32, 2 gives H/16, 3 gives H/8, 4 gives H/4, 5 gives H/2, 6 gives H − H/4, and 7 gives H. Every shift rounds down.
- R4: For slope codes 1 to 7 the step interval is N = floor(span/(level+1)), clamped to at least 1. The position moves one step toward the target at the N-th rising clock edge after a gate change, and again every N edges after that.
- R5: The position p runs from 0 to level+1. The output-enable equals (p ≠ 0), and the code equals p−1 when enabled and 0 otherwise. A rising ramp finishes at code = level with the enable high, and a falling ramp finishes with the enable low.
- R6: Slope code 0 moves the position to its target at the first clock edge after the gate changes.
- R7: A gate reversal partway through a ramp makes the ramp head for the new target from the present position, with the interval count started afresh.
- R8: A low channel enable forces that channel dark at the next edge. When the enable returns with the gate high, the channel ramps up from dark.
- R9: A level change while the gate is high moves the channel to the new level+1 position, using the slope code for that direction.
- R10: Channels are independent. One channel's gate activity leaves the other channels' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slope_cfg | input | 6 | Falling slope code [5:3], rising slope code [2:0] |
| period_ticks | input | PERIOD_W | Running blink period in clock ticks |
| ch_en | input | NUM_CH | Per-channel enable |
| gate | input | NUM_CH | Per-channel on/off gate from the blink sequencer |
| level | input | NUM_CH*5 | Per-channel programmed code, channel c at [5c+4:5c] |
| code_out | output | NUM_CH*5 | Per-channel instantaneous drive code |
| oe_out | output | NUM_CH | Per-channel output-enable |

## Verification
The main sweep drives rising and then falling ramps on one channel for every slope code, at two blink periods and at levels 0, 5 and 31. On every cycle the observed position is compared with floor(t/N) computed from the span formula. Because the falling code is set to the complement of the rising code, a swapped field shows up as wrong pacing in one direction. Levels 0 and 31 separate the division from the clamp to one tick. Directed cases cover a ramp reversed partway, dropping and restoring the enable, level changes with slope code 0, and a channel held lit that must stay put while its neighbour ramps.

// File: rtl/fade_pkg.sv
package fade_pkg;

    localparam int LVL_W  = 5;
    localparam int POS_W  = LVL_W + 1;
    localparam int CALC_W = 32;

    typedef enum logic [2:0] {
        SLP_NONE  = 3'd0,
        SLP_DIV32 = 3'd1,
        SLP_DIV16 = 3'd2,
        SLP_DIV8  = 3'd3,
        SLP_DIV4  = 3'd4,
        SLP_DIV2  = 3'd5,
        SLP_3Q    = 3'd6,
        SLP_FULL  = 3'd7
    } slope_e;

    // Group slope configuration: falling code in the upper field
    typedef struct packed {
        logic [2:0] fall;
        logic [2:0] rise;
    } slope_cfg_t;

    // Ramp span as a fraction of half the blink period
    function automatic logic [CALC_W-1:0] ramp_span(
        input logic [CALC_W-1:0] half,
        input slope_e            code
    );
        logic [CALC_W-1:0] span;
        case (code)
            SLP_DIV32: span = half >> 5;
            SLP_DIV16: span = half >> 4;
            SLP_DIV8:  span = half >> 3;
            SLP_DIV4:  span = half >> 2;
            SLP_DIV2:  span = half >> 1;
            SLP_3Q:    span = half - (half >> 2);
            SLP_FULL:  span = half;
            default:   span = '0;
        endcase
        return span;
    endfunction

    // Restoring unsigned division, floor(num/den); den is never zero here
    function automatic logic [CALC_W-1:0] udiv_floor(
        input logic [CALC_W-1:0] num,
        input logic [CALC_W-1:0] den
    );
        logic [CALC_W:0]   rem;
        logic [CALC_W-1:0] quo;
        rem = '0;
        quo = '0;
        for (int i = CALC_W - 1; i >= 0; i--) begin
            rem = {rem[CALC_W-1:0], num[i]};
            if (rem >= {1'b0, den}) begin
                rem    = rem - {1'b0, den};
                quo[i] = 1'b1;
            end
        end
        return quo;
    endfunction

endpackage

// File: rtl/fade_interval.sv
module fade_interval
    import fade_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic [PERIOD_W-1:0] period_ticks,
    input  slope_e              code,
    input  logic [LVL_W-1:0]    level,
    output logic [PERIOD_W-1:0] interval
);
    logic [CALC_W-1:0] half;
    logic [CALC_W-1:0] span;
    logic [CALC_W-1:0] steps;
    logic [CALC_W-1:0] quo;

    always_comb begin
        half  = CALC_W'(period_ticks) >> 1;
        span  = ramp_span(half, code);
        steps = CALC_W'(level) + 1;
        quo   = udiv_floor(span, steps);
        if (quo == '0)
            interval = PERIOD_W'(1);
        else
            interval = PERIOD_W'(quo);
    end

endmodule

// File: rtl/fade_channel.sv
module fade_channel
    import fade_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                gate,
    input  logic [LVL_W-1:0]    level,
    input  logic [PERIOD_W-1:0] period_ticks,
    input  slope_cfg_t          cfg,
    output logic [LVL_W-1:0]    code,
    output logic                oe
);
    logic [POS_W-1:0]    pos;
    logic [POS_W-1:0]    target;
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] cnt_eff;
    logic [PERIOD_W-1:0] interval;
    logic                gate_q;
    logic                rising;
    logic                restart;
    slope_e              slope_sel;

    always_comb begin
        target    = gate ? (POS_W'(level) + POS_W'(1)) : '0;
        rising    = target > pos;
        slope_sel = rising ? slope_e'(cfg.rise) : slope_e'(cfg.fall);
        restart   = gate ^ gate_q;
        cnt_eff   = restart ? '0 : cnt;
    end

    fade_interval #(.PERIOD_W(PERIOD_W)) interval_i (
        .period_ticks (period_ticks),
        .code         (slope_sel),
        .level        (level),
        .interval     (interval)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            cnt    <= '0;
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (!en) begin
                pos <= '0;
                cnt <= '0;
            end else if (pos == target) begin
                cnt <= '0;
            end else if (slope_sel == SLP_NONE) begin
                pos <= target;
                cnt <= '0;
            end else if (cnt_eff == interval - PERIOD_W'(1)) begin
                pos <= rising ? pos + POS_W'(1) : pos - POS_W'(1);
                cnt <= '0;
            end else begin
                cnt <= cnt_eff + PERIOD_W'(1);
            end
        end
    end

    always_comb begin
        oe   = (pos != '0);
        code = oe ? LVL_W'(pos - POS_W'(1)) : '0;
    end

    AST_DIS_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pos == '0)); // R8

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (en && slope_sel != SLP_NONE) |=>
            (int'(pos) <= int'($past(pos)) + 1 && int'(pos) + 1 >= int'($past(pos)))); // R4

    AST_NO_SLOPE_JUMP: assert property (@(posedge clk) disable iff (rst)
        (en && slope_sel == SLP_NONE) |=> (pos == $past(target))); // R6

    AST_TOWARD_TARGET: assert property (@(posedge clk) disable iff (rst)
        (en && pos != target) |=>
            (($past(target) > $past(pos)) ? (pos >= $past(pos)) : (pos <= $past(pos)))); // R7

endmodule

// File: rtl/fade_slope_gen.sv
module fade_slope_gen
    import fade_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int PERIOD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [5:0]              slope_cfg,
    input  logic [PERIOD_W-1:0]     period_ticks,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH-1:0]       gate,
    input  logic [NUM_CH*LVL_W-1:0] level,
    output logic [NUM_CH*LVL_W-1:0] code_out,
    output logic [NUM_CH-1:0]       oe_out
);
    slope_cfg_t cfg;
    assign cfg = slope_cfg_t'(slope_cfg);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fade_channel #(.PERIOD_W(PERIOD_W)) ch_i (
            .clk          (clk),
            .rst          (rst),
            .en           (ch_en[c]),
            .gate         (gate[c]),
            .level        (level[c*LVL_W +: LVL_W]),
            .period_ticks (period_ticks),
            .cfg          (cfg),
            .code         (code_out[c*LVL_W +: LVL_W]),
            .oe           (oe_out[c])
        );
    end

    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> (oe_out == '0)); // R1

endmodule

// File: tb/fade_slope_gen_tb_top.sv
`timescale 1ns/1ps
module fade_slope_gen_tb_top;
    localparam int NUM_CH   = 3;
    localparam int PERIOD_W = 16;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [5:0]            slope_cfg = '0;
    logic [PERIOD_W-1:0]   period_ticks = '0;
    logic [NUM_CH-1:0]     ch_en = '1;
    logic [NUM_CH-1:0]     gate = '0;
    logic [NUM_CH*5-1:0]   level = '0;
    logic [NUM_CH*5-1:0]   code_out;
    logic [NUM_CH-1:0]     oe_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    fade_slope_gen #(.NUM_CH(NUM_CH), .PERIOD_W(PERIOD_W)) dut_i (
        .clk(clk), .rst(rst), .slope_cfg(slope_cfg), .period_ticks(period_ticks),
        .ch_en(ch_en), .gate(gate), .level(level),
        .code_out(code_out), .oe_out(oe_out)
    );

    function automatic int exp_n(int per, int sc, int lvl);
        int h, span, n;
        h = per / 2;
        case (sc)
            1: span = h / 32;
            2: span = h / 16;
            3: span = h / 8;
            4: span = h / 4;
            5: span = h / 2;
            6: span = h - h / 4;
            7: span = h;
            default: return 0;
        endcase
        n = span / (lvl + 1);
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int pos_of(int ch);
        return oe_out[ch] ? int'(code_out[ch*5 +: 5]) + 1 : 0;
    endfunction

    // One check: position each cycle follows p0 toward tgt at one step per n edges
    task automatic ramp_check(input int ch, input int p0, input int tgt, input int n,
                              input int cycles, input string req);
        bit bad = 0;
        int act = 0, exp = 0, at = 0;
        for (int t = 1; t <= cycles; t++) begin
            int e, a;
            @(negedge clk);
            if (n == 0) e = tgt;
            else if (tgt > p0) e = (p0 + t / n > tgt) ? tgt : p0 + t / n;
            else e = (p0 - t / n < tgt) ? tgt : p0 - t / n;
            a = pos_of(ch);
            if (!oe_out[ch] && code_out[ch*5 +: 5] != 0 && !bad) begin
                bad = 1; act = int'(code_out[ch*5 +: 5]); exp = 0; at = -t;
            end
            if (a != e && !bad) begin
                bad = 1; act = a; exp = e; at = t;
            end
        end
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s ch%0d cycle %0d actual %0d expected %0d", req, ch, at, act, exp);
        end
    endtask

    task automatic check_eq(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        int pers[2];
        int lvls[3];
        pers[0] = 64;  pers[1] = 200;
        lvls[0] = 0;   lvls[1] = 5;   lvls[2] = 31;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_eq(int'(oe_out), 0, "R1 oe");
        check_eq(int'(code_out), 0, "R1 code");

        // Channel 2 held lit through the sweep (slope 0 jumps immediately)
        level[2*5 +: 5] = 5'd9;
        gate[2] = 1'b1;
        @(negedge clk);
        check_eq(pos_of(2), 10, "R6 ch2 immediate");

        // Sweep: R2 R3 R4 R5 R6 — rising code sc, falling code 7-sc
        for (int pi = 0; pi < 2; pi++) begin
            for (int sc = 0; sc < 8; sc++) begin
                for (int li = 0; li < 3; li++) begin
                    int ni, no, len;
                    period_ticks = PERIOD_W'(pers[pi]);
                    slope_cfg = {3'(7 - sc), 3'(sc)};
                    level[0 +: 5] = 5'(lvls[li]);
                    ni = exp_n(pers[pi], sc, lvls[li]);
                    no = exp_n(pers[pi], 7 - sc, lvls[li]);
                    gate[0] = 1'b1;
                    len = (lvls[li] + 1) * (ni == 0 ? 1 : ni) + 3;
                    ramp_check(0, 0, lvls[li] + 1, ni, len, "R2 R3 R4 R5 rise");
                    gate[0] = 1'b0;
                    len = (lvls[li] + 1) * (no == 0 ? 1 : no) + 3;
                    ramp_check(0, lvls[li] + 1, 0, no, len, "R2 R3 R4 R5 fall");
                end
            end
        end

        // R10: neighbours untouched by channel 0 activity
        check_eq(pos_of(2), 10, "R10 ch2 held");
        check_eq(pos_of(1), 0, "R10 ch1 dark");

        // R7: reversal partway through a ramp (half 64, code 7, level 7 -> N = 8)
        period_ticks = PERIOD_W'(128);
        slope_cfg = {3'd7, 3'd7};
        level[0 +: 5] = 5'd7;
        gate[0] = 1'b1;
        ramp_check(0, 0, 8, 8, 20, "R7 pre");
        gate[0] = 1'b0;
        ramp_check(0, 2, 0, 8, 24, "R7 reversal");

        // R8: enable drop and return (half 64, code 3 -> span 8, level 10 -> N = 1)
        slope_cfg = {3'd0, 3'd3};
        level[0 +: 5] = 5'd10;
        gate[0] = 1'b1;
        ramp_check(0, 0, 11, 1, 14, "R8 lit");
        ch_en[0] = 1'b0;
        @(negedge clk);
        check_eq(pos_of(0), 0, "R8 disabled dark");
        check_eq(int'(code_out[0 +: 5]), 0, "R8 code zero");
        ch_en[0] = 1'b1;
        ramp_check(0, 0, 11, 1, 14, "R8 re-ramp");

        // R9: level changes with gate high under slope code 0
        level[0 +: 5] = 5'd4;
        ramp_check(0, 11, 5, 0, 3, "R9 lower");
        slope_cfg = {3'd0, 3'd0};
        level[0 +: 5] = 5'd20;
        ramp_check(0, 5, 21, 0, 3, "R9 raise");
        check_eq(pos_of(2), 10, "R10 ch2 final");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule